// File: doc/BRIEF.md
# Four-Lane SIMD Multiply-Accumulate Unit

This block is a two-stage pipelined datapath for the inner loops of integer neural-network inference. Each cycle it can accept two operand words. Each word packs four 8-bit lanes. Stage one applies one selected element-wise operation to all four lane pairs at once: an unsigned, a signed or a mixed signed-by-unsigned multiply, or a lane subtract. It registers four 16-bit lane results. Stage two sums the four results and either loads that sum into a 32-bit accumulator or adds it to the running total.

A host streams operand pairs with a valid strobe. On the first pair of a dot product it raises the clear control, so the old total is discarded. It raises the hold control when a result must pass through without touching the total. Lanes that carry zero padding add nothing, so a partly filled word still gives an exact dot product. The stage-two adders sit in their own module. An approximate adder can replace them while the stage-one multipliers stay exact.

Top module: `simd_mac`

## Requirements
- R1: Lane k of each operand word sits at bits 8k+7:8k (lane 0 at 7:0, lane 3 at 31:24). Operation code 0 multiplies each lane pair as two unsigned 8-bit numbers and gives an unsigned product.
- R2: Operation code 1 multiplies each lane pair as two signed two's-complement 8-bit numbers and gives a signed product.
- R3: Operation code 2 multiplies the lane of operand A, taken as signed 8-bit, by the lane of operand B, taken as unsigned 8-bit, and gives a signed product.
- R4: Operation code 3 subtracts the B lane from the A lane, both taken as unsigned 8-bit, and gives a signed difference in the range -255 to 255.
- R5: Stage two sums the four lane results. Under code 0 it extends each 16-bit result with zeros; under codes 1 to 3 it extends each with its sign.
- R6: A valid result with clear high and hold low loads the accumulator with the lane sum and drops the previous total.
- R7: A valid result with clear low and hold low adds the lane sum to the accumulator, modulo 2^32.
- R8: A valid result with hold high leaves the accumulator unchanged, whatever the state of clear.
- R9: Cycles with in_valid low leave the accumulator unchanged, whatever data and controls are applied.
- R10: out_valid rises two clock edges after an accepted input. The accumulator shows that input's effect in the same cycle.
- R11: A lane pair whose A or B lane is zero under any multiply code, or whose A and B lanes are both zero under code 3, adds nothing to the sum.
- R12: While reset is asserted and after reset is released, before any input is accepted, the accumulator reads 0 and out_valid reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand pair and controls are valid this cycle |
| op_sel | input | 2 | Lane operation: 0 unsigned mul, 1 signed mul, 2 signed-by-unsigned mul, 3 subtract |
| opnd_a | input | 32 | Operand A, four 8-bit lanes |
| opnd_b | input | 32 | Operand B, four 8-bit lanes |
| acc_clr | input | 1 | Load accumulator with the new sum instead of adding |
| acc_hold | input | 1 | Leave accumulator unchanged for this result |
| out_valid | output | 1 | A result reached stage two on the previous edge |
| acc_out | output | 32 | Accumulator value |

## Verification
The bench builds the block with its default parameters: four 8-bit lanes, 16-bit lane results and a 32-bit accumulator. At this size every value of the A lane, for each of the four operation codes, can be streamed against a spread of B values in a few thousand cycles each. Each lane gets a different offset, so every lane position sees sign boundaries such as -128 and 255. The bench also uses runs that carry the total below zero and back across the 2^32 wrap, and sequences that mix clear, hold and idle cycles.

// File: rtl/simd_mac_pkg.sv
package simd_mac_pkg;

   typedef enum logic [1:0] {
      OP_MUL_UU = 2'd0,
      OP_MUL_SS = 2'd1,
      OP_MUL_SU = 2'd2,
      OP_SUB    = 2'd3
   } lane_op_e;

   // Whether a lane result is to be read as a two's-complement value
   function automatic logic op_is_signed(lane_op_e op);
      return op != OP_MUL_UU;
   endfunction

endpackage

// File: rtl/simd_lane_alu.sv
module simd_lane_alu
   import simd_mac_pkg::*;
#(
   parameter int LANE_W = 8,
   parameter int RES_W  = 16
) (
   input  lane_op_e            op,
   input  logic [LANE_W-1:0]   a,
   input  logic [LANE_W-1:0]   b,
   output logic [RES_W-1:0]    res
);
   localparam int XW = (RES_W > 2*LANE_W+2) ? RES_W : 2*LANE_W+2;

   generate
      if (RES_W < 2*LANE_W) begin : g_bad_width
         $error("simd_lane_alu: RES_W must hold a full lane product");
      end
   endgenerate

   logic signed [LANE_W:0] a_x, b_x;
   logic signed [XW-1:0]   prod, diff;

   always_comb begin
      // operand A is signed for both signed and mixed multiply
      a_x  = (op == OP_MUL_SS || op == OP_MUL_SU) ? $signed({a[LANE_W-1], a})
                                                  : $signed({1'b0, a});
      b_x  = (op == OP_MUL_SS) ? $signed({b[LANE_W-1], b})
                               : $signed({1'b0, b});
      prod = XW'(a_x) * XW'(b_x);
      diff = XW'(a_x) - XW'(b_x);
      res  = (op == OP_SUB) ? diff[RES_W-1:0] : prod[RES_W-1:0];
   end

   // a lane difference never needs more than LANE_W+1 significant bits
   always_comb begin
      if (op == OP_SUB) begin
         p_sub_range_r4: assert (res[RES_W-1:LANE_W] == '0 || res[RES_W-1:LANE_W] == '1);
      end
   end

endmodule

// File: rtl/simd_reduce_acc.sv
module simd_reduce_acc #(
   parameter int LANES = 4,
   parameter int RES_W = 16,
   parameter int ACC_W = 32
) (
   input  logic [LANES*RES_W-1:0] lane_res,
   input  logic                   lane_signed,
   input  logic [ACC_W-1:0]       acc_in,
   input  logic                   load,
   output logic [ACC_W-1:0]       lane_sum,
   output logic [ACC_W-1:0]       acc_next
);
   generate
      if (ACC_W < RES_W + $clog2(LANES)) begin : g_bad_width
         $error("simd_reduce_acc: ACC_W too narrow for the lane sum");
      end
   endgenerate

   logic [ACC_W-1:0] ext [LANES];

   genvar gi;
   generate
      for (gi = 0; gi < LANES; gi++) begin : g_ext
         logic [RES_W-1:0] r;
         assign r       = lane_res[gi*RES_W +: RES_W];
         assign ext[gi] = {{(ACC_W-RES_W){lane_signed & r[RES_W-1]}}, r};
      end
   endgenerate

   always_comb begin
      lane_sum = '0;
      for (int i = 0; i < LANES; i++) lane_sum = lane_sum + ext[i];
   end

   assign acc_next = load ? lane_sum : acc_in + lane_sum;

endmodule

// File: rtl/simd_mac.sv
module simd_mac
   import simd_mac_pkg::*;
#(
   parameter int LANES  = 4,
   parameter int LANE_W = 8,
   parameter int RES_W  = 16,
   parameter int ACC_W  = 32
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid,
   input  logic [1:0]              op_sel,
   input  logic [LANES*LANE_W-1:0] opnd_a,
   input  logic [LANES*LANE_W-1:0] opnd_b,
   input  logic                    acc_clr,
   input  logic                    acc_hold,
   output logic                    out_valid,
   output logic [ACC_W-1:0]        acc_out
);
   localparam int RW = LANES*RES_W;

   generate
      if (LANES < 1 || LANE_W < 2) begin : g_bad_cfg
         $error("simd_mac: need at least one lane of two bits");
      end
   endgenerate

   lane_op_e      op_in;
   logic [RW-1:0] lane_res;
   assign op_in = lane_op_e'(op_sel);

   genvar gl;
   generate
      for (gl = 0; gl < LANES; gl++) begin : g_lane
         simd_lane_alu #(.LANE_W(LANE_W), .RES_W(RES_W)) u_alu (
            .op  (op_in),
            .a   (opnd_a[gl*LANE_W +: LANE_W]),
            .b   (opnd_b[gl*LANE_W +: LANE_W]),
            .res (lane_res[gl*RES_W +: RES_W])
         );
      end
   endgenerate

   // stage one registers
   logic          s1_valid, s1_signed, s1_clr, s1_hold;
   logic [RW-1:0] s1_res;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_valid  <= 1'b0;
         s1_signed <= 1'b0;
         s1_clr    <= 1'b0;
         s1_hold   <= 1'b0;
         s1_res    <= '0;
      end else begin
         s1_valid <= in_valid;
         if (in_valid) begin
            s1_signed <= op_is_signed(op_in);
            s1_clr    <= acc_clr;
            s1_hold   <= acc_hold;
            s1_res    <= lane_res;
         end
      end
   end

   // stage two: reduction and accumulator
   logic [ACC_W-1:0] lane_sum, acc_next, acc_q;

   simd_reduce_acc #(.LANES(LANES), .RES_W(RES_W), .ACC_W(ACC_W)) u_reduce (
      .lane_res    (s1_res),
      .lane_signed (s1_signed),
      .acc_in      (acc_q),
      .load        (s1_clr),
      .lane_sum    (lane_sum),
      .acc_next    (acc_next)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q     <= '0;
         out_valid <= 1'b0;
      end else begin
         out_valid <= s1_valid;
         if (s1_valid && !s1_hold) acc_q <= acc_next;
      end
   end

   assign acc_out = acc_q;

   p_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (s1_valid && s1_clr && !s1_hold) |=> (acc_q == $past(lane_sum)));

   p_accum_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (s1_valid && !s1_clr && !s1_hold) |=> (acc_q == $past(acc_q) + $past(lane_sum)));

   p_hold_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (s1_valid && s1_hold) |=> $stable(acc_q));

   p_idle_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !s1_valid |=> $stable(acc_q));

   p_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |-> ##2 out_valid);

endmodule

// File: tb/simd_mac_bench.sv
module simd_mac_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [1:0]  op_sel = '0;
   logic [31:0] opnd_a = '0, opnd_b = '0;
   logic        acc_clr = 1'b0, acc_hold = 1'b0;
   logic        out_valid;
   logic [31:0] acc_out;

   int n_checks = 0;
   int n_fail   = 0;

   always #10ns clk = ~clk;   // 50 MHz

   simd_mac u_simd_mac (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
      .opnd_a(opnd_a), .opnd_b(opnd_b), .acc_clr(acc_clr), .acc_hold(acc_hold),
      .out_valid(out_valid), .acc_out(acc_out)
   );

   // bench model state and two-deep expectation pipe
   logic [31:0] m_acc = '0;
   logic        p_v   [2] = '{1'b0, 1'b0};
   logic [31:0] p_acc [2] = '{32'd0, 32'd0};
   string       p_tag [2] = '{"R12", "R12"};

   function automatic int sx8(logic [7:0] v);
      return v[7] ? int'(v) - 256 : int'(v);
   endfunction

   function automatic int lane_val(logic [1:0] o, logic [7:0] a, logic [7:0] b);
      case (o)
         2'd0:    return int'(a) * int'(b);
         2'd1:    return sx8(a) * sx8(b);
         2'd2:    return sx8(a) * int'(b);
         default: return int'(a) - int'(b);
      endcase
   endfunction

   function automatic logic [31:0] word_sum(logic [1:0] o, logic [31:0] a, logic [31:0] b);
      int s = 0;
      for (int i = 0; i < 4; i++) s += lane_val(o, a[8*i +: 8], b[8*i +: 8]);
      return 32'(s);
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic step(input logic v, input logic [1:0] o, input logic [31:0] a,
                       input logic [31:0] b, input logic c, input logic h, input string tag);
      @(negedge clk);
      check({p_tag[1], " out_valid (R10)"}, {31'd0, out_valid}, {31'd0, p_v[1]});
      check(p_tag[1], acc_out, p_acc[1]);
      if (v && !h) m_acc = c ? word_sum(o, a, b) : m_acc + word_sum(o, a, b);
      in_valid = v; op_sel = o; opnd_a = a; opnd_b = b; acc_clr = c; acc_hold = h;
      p_v[1] = p_v[0];   p_acc[1] = p_acc[0];   p_tag[1] = p_tag[0];
      p_v[0] = v;        p_acc[0] = m_acc;      p_tag[0] = tag;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R12 acc in reset", acc_out, 32'd0);
      check("R12 valid in reset", {31'd0, out_valid}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R12 acc after reset", acc_out, 32'd0);
      check("R12 valid after reset", {31'd0, out_valid}, 32'd0);

      // R1 R2 R3 R4 R5: sweep all A values per code, clear every sample
      for (int o = 0; o < 4; o++) begin
         for (int av = 0; av < 256; av++) begin
            for (int bi = 0; bi < 16; bi++) begin
               logic [31:0] wa, wb;
               for (int k = 0; k < 4; k++) begin
                  wa[8*k +: 8] = 8'(av + 37*k);
                  wb[8*k +: 8] = 8'(bi*17 + 53*k);
               end
               step(1'b1, 2'(o), wa, wb, 1'b1, 1'b0,
                    o == 0 ? "R1 unsigned mul" : o == 1 ? "R2 signed mul" :
                    o == 2 ? "R3 mixed mul" : "R4 lane subtract");
            end
         end
      end

      // R7: go negative, then accumulate back across the 2^32 wrap
      step(1'b1, 2'd3, 32'h0000_0000, 32'hFFFF_FFFF, 1'b1, 1'b0, "R6 clear to negative");
      for (int i = 0; i < 6; i++)
         step(1'b1, 2'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 1'b0, "R7 accumulate wrap");
      for (int i = 0; i < 5; i++)
         step(1'b1, 2'd1, 32'h8080_8080, 32'h7F7F_7F7F, 1'b0, 1'b0, "R7 signed accumulate");

      // R8: hold, with and without clear
      step(1'b1, 2'd0, 32'h1234_5678, 32'h9ABC_DEF0, 1'b0, 1'b1, "R8 hold");
      step(1'b1, 2'd2, 32'hFFFF_FFFF, 32'h0102_0304, 1'b1, 1'b1, "R8 hold with clear");
      // R9: idle cycles with busy data
      step(1'b0, 2'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 1'b0, "R9 idle");
      step(1'b0, 2'd3, 32'h0000_0000, 32'hFFFF_FFFF, 1'b0, 1'b0, "R9 idle");
      step(1'b1, 2'd1, 32'h0000_0003, 32'h0000_0002, 1'b0, 1'b0, "R10 after idle");

      // R11: zero padding lanes in every mode
      step(1'b1, 2'd2, 32'h0000_0081, 32'hFFFF_FF02, 1'b1, 1'b0, "R11 padding mixed");
      step(1'b1, 2'd1, 32'hFF00_00FF, 32'h0080_8001, 1'b0, 1'b0, "R11 padding signed");
      step(1'b1, 2'd3, 32'h0000_0007, 32'h0000_0009, 1'b0, 1'b0, "R11 padding subtract");
      step(1'b1, 2'd0, 32'h00FF_0000, 32'hFF00_FFFF, 1'b0, 1'b0, "R11 padding unsigned");

      // R6: clear after a run drops old total
      step(1'b1, 2'd0, 32'h0101_0101, 32'h0202_0202, 1'b1, 1'b0, "R6 clear reload");
      step(1'b0, 2'd0, 32'h0, 32'h0, 1'b0, 1'b0, "R10 flush");
      step(1'b0, 2'd0, 32'h0, 32'h0, 1'b0, 1'b0, "R10 flush");
      step(1'b0, 2'd0, 32'h0, 32'h0, 1'b0, 1'b0, "R10 flush");

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule